// File: doc/BRIEF.md
# Nine-Level Staircase PWM Gate Sequencer

This block turns a signed reference sample into gate commands for a nine-switch, two-capacitor boosting inverter that produces nine output levels, from four units of input voltage below zero to four above. A shared up/down counter makes eight stacked triangular carriers. Each carrier covers one eighth of the signed reference range. The reference is first scaled by a run-time modulation index. The number of carriers it exceeds gives a level from -4 to +4.

The level is captured only at the counter's valley and peak. A switch-set table then converts it into a nine-bit gate vector. The table is irregular: some primed and unprimed switch pairs conduct together, level +2 takes its vector from an input, and level 0 has two switch sets chosen by the sign of the reference. A dead-time stage delays every newly asserted gate by a programmable number of cycles. Gates being released drop at once.

The defaults give a 5 kHz carrier at a 100 MHz clock (counter top 10000). At that clock, a dead time of 20 cycles is 200 ns. The intended value for the level +2 input is the level +1 switch set.

Top module: `nlpwm_gate_gen`

## Requirements
- R1: The carrier counter starts at 0 after reset and steps by one up to CARR_MAX, then back down to 0, so one switching period is 2*CARR_MAX cycles. A capture edge is any clock edge where the counter is at 0 (valley) or at CARR_MAX (peak).
- R2: Let s = floor(ref_i * m / 256) and u = s + 2^(REF_W-1), with band B = 2^(REF_W-3). At a valley capture, level_o becomes (number of k in 0..7 with u > k*B) - 4. At a peak capture, it becomes (number of k in 0..7 with u > (k+1)*B) - 4. level_o is a 4-bit two's complement value.
- R3: level_o and gate_o keep their value across every clock edge that is not a capture edge.
- R4: m is mod_i, where 256 means full scale. Any mod_i above 256 is treated as 256, so a smaller index reaches fewer levels.
- R5: gate_o bit positions are: 8 SRC_A, 7 SRC_B, 6 MID_A, 5 MID_B, 4 LINK, 3 CAP_A, 2 CAP_B, 1 OUT_A, 0 OUT_B. With no dead time pending, the asserted gates are:
  - level +4: {SRC_B, LINK, MID_A, CAP_A, OUT_A}
  - level +3: {SRC_B, MID_A, MID_B, CAP_A, OUT_A}
  - level +1: {SRC_B, LINK, MID_A, CAP_B, OUT_A}
  - level -1: {SRC_A, LINK, MID_A, CAP_A, OUT_B}
  - level -2: {SRC_A, LINK, MID_B, CAP_A, OUT_B}
  - level -3: {SRC_A, MID_A, MID_B, CAP_B, OUT_B}
  - level -4: {SRC_B, LINK, MID_B, CAP_B, OUT_B}
- R6: Level +2 drives the vector on lvl2_vec_i, sampled at the capture edge.
- R7: A half-cycle flag is set at a capture edge when ref_i > 0, cleared when ref_i < 0, and held when ref_i = 0. It is set after reset. Level 0 drives {SRC_B, LINK, MID_A, CAP_A, OUT_B} when the flag is set and {SRC_A, LINK, MID_B, CAP_B, OUT_A} when it is clear.
- R8: When a capture edge changes the target vector, dead_i is loaded as the dead time D. Gates that leave the target drop on that edge. Gates that join the target stay low for D cycles and rise on the D-th edge after the change. With D = 0 they rise on the change edge.
- R9: During reset, gate_o is all zeros and level_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_i | input | REF_W (16) | Signed reference sample |
| mod_i | input | MOD_W (9) | Modulation index, 256 = full scale |
| lvl2_vec_i | input | 9 | Gate vector used for level +2 |
| dead_i | input | DT_W (8) | Dead time in clock cycles |
| gate_o | output | 9 | Gate commands, bit map as in R5 |
| level_o | output | 4 | Captured level, two's complement |

## Verification
The bench sweeps references across the whole signed range, including one count on each side of every band threshold, at several modulation indices (one of them above full scale), at both valley and peak captures. An off-by-one threshold or a swapped peak/valley offset would move level_o by one step. A reference change placed between capture edges checks that the level cannot move mid-period; a design that decoded continuously would switch early. Further checks cover:
- both zero-level switch sets, including a zero reference that must keep the last half;
- the programmable level +2 vector;
- a +4 to -4 swing under dead time, where a stage that delayed released gates, or let new ones through early, would show overlapping or missing gates.

// File: rtl/nlpwm_pkg.sv
package nlpwm_pkg;

  typedef logic [8:0] gate_vec_t;

  // gate bit positions
  localparam int SW_OUT_B = 0;
  localparam int SW_OUT_A = 1;
  localparam int SW_CAP_B = 2;
  localparam int SW_CAP_A = 3;
  localparam int SW_LINK  = 4;
  localparam int SW_MID_B = 5;
  localparam int SW_MID_A = 6;
  localparam int SW_SRC_B = 7;
  localparam int SW_SRC_A = 8;

  function automatic gate_vec_t sw(input int idx);
    return gate_vec_t'(1) << idx;
  endfunction

  localparam gate_vec_t GV_ZERO_POS = sw(SW_SRC_B) | sw(SW_LINK) | sw(SW_MID_A) | sw(SW_CAP_A) | sw(SW_OUT_B);
  localparam gate_vec_t GV_ZERO_NEG = sw(SW_SRC_A) | sw(SW_LINK) | sw(SW_MID_B) | sw(SW_CAP_B) | sw(SW_OUT_A);
  localparam gate_vec_t GV_POS1 = sw(SW_SRC_B) | sw(SW_LINK) | sw(SW_MID_A) | sw(SW_CAP_B) | sw(SW_OUT_A);
  localparam gate_vec_t GV_POS3 = sw(SW_SRC_B) | sw(SW_MID_A) | sw(SW_MID_B) | sw(SW_CAP_A) | sw(SW_OUT_A);
  localparam gate_vec_t GV_POS4 = sw(SW_SRC_B) | sw(SW_LINK) | sw(SW_MID_A) | sw(SW_CAP_A) | sw(SW_OUT_A);
  localparam gate_vec_t GV_NEG1 = sw(SW_SRC_A) | sw(SW_LINK) | sw(SW_MID_A) | sw(SW_CAP_A) | sw(SW_OUT_B);
  localparam gate_vec_t GV_NEG2 = sw(SW_SRC_A) | sw(SW_LINK) | sw(SW_MID_B) | sw(SW_CAP_A) | sw(SW_OUT_B);
  localparam gate_vec_t GV_NEG3 = sw(SW_SRC_A) | sw(SW_MID_A) | sw(SW_MID_B) | sw(SW_CAP_B) | sw(SW_OUT_B);
  localparam gate_vec_t GV_NEG4 = sw(SW_SRC_B) | sw(SW_LINK) | sw(SW_MID_B) | sw(SW_CAP_B) | sw(SW_OUT_B);

  // level (4-bit two's complement) to switch set
  function automatic gate_vec_t gate_for_level(input logic [3:0] lvl,
                                               input logic pos_half,
                                               input gate_vec_t lvl2_vec);
    gate_vec_t v;
    case (lvl)
      4'h4:    v = GV_POS4;
      4'h3:    v = GV_POS3;
      4'h2:    v = lvl2_vec;
      4'h1:    v = GV_POS1;
      4'hF:    v = GV_NEG1;
      4'hE:    v = GV_NEG2;
      4'hD:    v = GV_NEG3;
      4'hC:    v = GV_NEG4;
      default: v = pos_half ? GV_ZERO_POS : GV_ZERO_NEG;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nlpwm_carrier.sv
module nlpwm_carrier #(
  parameter int CNT_W    = 16,
  parameter int CARR_MAX = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             smp_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CARR_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q == TOP) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign smp_o = (cnt_q == '0) || (cnt_q == TOP);
endmodule

// File: rtl/nlpwm_level_dec.sv
module nlpwm_level_dec #(
  parameter int REF_W    = 16,
  parameter int MOD_W    = 9,
  parameter int CNT_W    = 16,
  parameter int CARR_MAX = 10000
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [MOD_W-1:0]        mod_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [3:0]              level_o
);
  localparam int NCARR   = 8;
  localparam int BAND_SH = REF_W - 3;
  localparam int PROD_W  = REF_W + MOD_W + 1;
  localparam int CMP_W   = REF_W + CNT_W + 5;
  localparam logic [MOD_W-1:0] MOD_ONE = MOD_W'(1 << (MOD_W - 1));

  // scaled reference moved onto an unsigned axis
  function automatic logic [REF_W-1:0] to_position(input logic signed [REF_W-1:0] r,
                                                   input logic [MOD_W-1:0] m);
    logic [MOD_W-1:0]         me;
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] s;
    me = (m > MOD_ONE) ? MOD_ONE : m;
    p  = PROD_W'(r) * $signed({1'b0, me});
    s  = p >>> (MOD_W - 1);
    return {~s[REF_W-1], s[REF_W-2:0]};
  endfunction

  // carrier k = k*B + cnt*B/CARR_MAX, compared without division
  function automatic logic above_carrier(input logic [REF_W-1:0] u, input int k,
                                         input logic [CNT_W-1:0] c);
    logic [CMP_W-1:0] lhs;
    logic [CMP_W-1:0] rhs;
    lhs = CMP_W'(u) * CMP_W'(CARR_MAX);
    rhs = (CMP_W'(k) * CMP_W'(CARR_MAX) + CMP_W'(c)) << BAND_SH;
    return lhs > rhs;
  endfunction

  logic [REF_W-1:0] pos_w;
  logic [3:0]       lower_w;
  logic [3:0]       upper_w;
  logic [3:0]       n_above;

  assign pos_w = to_position(ref_i, mod_i);

  for (genvar k = 0; k < NCARR / 2; k++) begin : g_band
    assign lower_w[k] = above_carrier(pos_w, k, cnt_i);
    assign upper_w[k] = above_carrier(pos_w, k + NCARR / 2, cnt_i);
  end

  always_comb begin
    n_above = '0;
    for (int k = 0; k < NCARR / 2; k++) begin
      n_above = n_above + 4'(lower_w[k]) + 4'(upper_w[k]);
    end
  end

  assign level_o = n_above - 4'd4;
endmodule

// File: rtl/nlpwm_deadtime.sv
module nlpwm_deadtime #(
  parameter int DT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  nlpwm_pkg::gate_vec_t       tgt_i,
  input  logic [DT_W-1:0]            dead_i,
  output nlpwm_pkg::gate_vec_t       gate_o,
  output logic                       busy_o
);
  nlpwm_pkg::gate_vec_t tgt_q;
  nlpwm_pkg::gate_vec_t keep_q;
  logic [DT_W-1:0]      dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      keep_q <= '0;
      dt_q   <= '0;
    end else if (load_i && (tgt_i != tgt_q)) begin
      tgt_q  <= tgt_i;
      keep_q <= gate_o;
      dt_q   <= dead_i;
    end else if (dt_q != '0) begin
      dt_q <= dt_q - 1'b1;
    end
  end

  assign busy_o = (dt_q != '0);
  assign gate_o = tgt_q & (busy_o ? keep_q : '1);
endmodule

// File: rtl/nlpwm_gate_gen.sv
module nlpwm_gate_gen #(
  parameter int REF_W    = 16,
  parameter int MOD_W    = 9,
  parameter int CNT_W    = 16,
  parameter int CARR_MAX = 10000,
  parameter int DT_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [MOD_W-1:0]        mod_i,
  input  logic [8:0]              lvl2_vec_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [8:0]              gate_o,
  output logic [3:0]              level_o
);
  import nlpwm_pkg::*;

  logic [CNT_W-1:0] cnt_w;
  logic             smp_w;
  logic [3:0]       lvl_now_w;
  logic             half_next_w;
  gate_vec_t        tgt_new_w;
  logic             dt_busy_w;
  logic [3:0]       lvl_q;
  logic             half_q;

  nlpwm_carrier #(.CNT_W(CNT_W), .CARR_MAX(CARR_MAX)) u_car (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt_w), .smp_o(smp_w)
  );

  nlpwm_level_dec #(.REF_W(REF_W), .MOD_W(MOD_W), .CNT_W(CNT_W), .CARR_MAX(CARR_MAX)) u_dec (
    .ref_i(ref_i), .mod_i(mod_i), .cnt_i(cnt_w), .level_o(lvl_now_w)
  );

  // half-cycle flag follows the sign, holds on zero
  assign half_next_w = ref_i[REF_W-1] ? 1'b0 : ((ref_i != '0) ? 1'b1 : half_q);
  assign tgt_new_w   = gate_for_level(lvl_now_w, half_next_w, lvl2_vec_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      half_q <= 1'b1;
    end else if (smp_w) begin
      lvl_q  <= lvl_now_w;
      half_q <= half_next_w;
    end
  end

  nlpwm_deadtime #(.DT_W(DT_W)) u_dt (
    .clk(clk), .rst_n(rst_n), .load_i(smp_w), .tgt_i(tgt_new_w),
    .dead_i(dead_i), .gate_o(gate_o), .busy_o(dt_busy_w)
  );

  assign level_o = lvl_q;
endmodule

// File: rtl/nlpwm_gate_chk.sv
module nlpwm_gate_chk #(
  parameter int CNT_W    = 16,
  parameter int CARR_MAX = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             smp,
  input logic [3:0]       level,
  input logic [8:0]       gate,
  input logic             busy
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CARR_MAX);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n) cnt <= TOP);
  assert_valley_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (cnt == CNT_W'(1)));
  assert_peak_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP) |=> (cnt == TOP - 1'b1));
  assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(level) >= -4) && ($signed(level) <= 4));
  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(level));
  assert_no_early_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((gate & ~$past(gate)) == 9'd0));
  assert_five_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && level != 4'd0 && level != 4'd2) |-> ($countones(gate) == 5));
endmodule

bind nlpwm_gate_gen nlpwm_gate_chk #(.CNT_W(CNT_W), .CARR_MAX(CARR_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .smp(smp_w),
  .level(level_o), .gate(gate_o), .busy(dt_busy_w)
);

// File: tb/nlpwm_gate_gen_tb_top.sv
`timescale 1ns/1ps
module nlpwm_gate_gen_tb_top;
  localparam int M = 16;

  // switch indexes restated for the bench
  localparam int IB_OUT_B = 0, IB_OUT_A = 1, IB_CAP_B = 2, IB_CAP_A = 3, IB_LINK = 4;
  localparam int IB_MID_B = 5, IB_MID_A = 6, IB_SRC_B = 7, IB_SRC_A = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [15:0] ref_s = '0;
  logic [8:0]         mod_s = 9'd256;
  logic [8:0]         l2_s;
  logic [7:0]         dead_s = '0;
  logic [8:0]         gate_w;
  logic [3:0]         level_w;

  int nchk = 0, nfail = 0, e = 0;
  bit half_m = 1'b1;

  always #2.5 clk = ~clk;

  nlpwm_gate_gen #(.CARR_MAX(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_s), .mod_i(mod_s),
    .lvl2_vec_i(l2_s), .dead_i(dead_s), .gate_o(gate_w), .level_o(level_w)
  );

  function automatic logic [8:0] b(input int i);
    return 9'(1 << i);
  endfunction

  function automatic logic [8:0] exp_gate(input int lvl, input bit pos, input logic [8:0] l2);
    case (lvl)
      4:  return b(IB_OUT_A) | b(IB_CAP_A) | b(IB_MID_A) | b(IB_LINK) | b(IB_SRC_B);
      3:  return b(IB_OUT_A) | b(IB_CAP_A) | b(IB_MID_B) | b(IB_MID_A) | b(IB_SRC_B);
      2:  return l2;
      1:  return b(IB_OUT_A) | b(IB_CAP_B) | b(IB_MID_A) | b(IB_LINK) | b(IB_SRC_B);
      -1: return b(IB_OUT_B) | b(IB_CAP_A) | b(IB_MID_A) | b(IB_LINK) | b(IB_SRC_A);
      -2: return b(IB_OUT_B) | b(IB_CAP_A) | b(IB_MID_B) | b(IB_LINK) | b(IB_SRC_A);
      -3: return b(IB_OUT_B) | b(IB_CAP_B) | b(IB_MID_B) | b(IB_MID_A) | b(IB_SRC_A);
      -4: return b(IB_OUT_B) | b(IB_CAP_B) | b(IB_MID_B) | b(IB_LINK) | b(IB_SRC_B);
      default: return pos ? (b(IB_OUT_B) | b(IB_CAP_A) | b(IB_MID_A) | b(IB_LINK) | b(IB_SRC_B))
                          : (b(IB_OUT_A) | b(IB_CAP_B) | b(IB_MID_B) | b(IB_LINK) | b(IB_SRC_A));
    endcase
  endfunction

  function automatic int exp_level(input int r, input int m, input bit valley);
    int me = (m > 256) ? 256 : m;
    int s = (r * me) >>> 8;
    int u = s + 32768;
    int c = 0;
    for (int k = 0; k < 8; k++) if (u > (valley ? k : k + 1) * 8192) c++;
    return c - 4;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  function automatic bit is_valley(input int n); return (n % (2 * M)) == 0; endfunction
  function automatic bit is_peak(input int n);   return (n % (2 * M)) == M; endfunction

  task automatic tick();
    if (is_valley(e) || is_peak(e)) begin
      if (ref_s > 0) half_m = 1'b1;
      else if (ref_s < 0) half_m = 1'b0;
    end
    @(posedge clk);
    e++;
    @(negedge clk);
  endtask

  task automatic wait_strobe(input bit valley);
    while (!(valley ? is_valley(e) : is_peak(e))) tick();
  endtask

  // capture one reference at a strobe and check level and gate (dead time 0)
  task automatic cap_check(input int r, input int m, input bit valley, input string why);
    int lv;
    logic [8:0] g;
    wait_strobe(valley);
    ref_s = 16'(r);
    mod_s = 9'(m);
    tick();
    lv = exp_level(r, m, valley);
    check($signed(level_w) == lv, $sformatf("R2 level %s r=%0d m=%0d v=%0d", why, r, m, valley),
          $signed(level_w), lv);
    g = exp_gate(lv, half_m, l2_s);
    check(gate_w == g, $sformatf("%s gate lvl=%0d", (lv == 0) ? "R7" : (lv == 2) ? "R6" : "R5", lv),
          gate_w, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int mlist[5] = '{256, 192, 128, 64, 300};
    logic [8:0] oldg, newg;
    l2_s = exp_gate(1, 1'b1, 9'd0);
    repeat (3) @(negedge clk);
    check(gate_w == 9'd0, "R9 reset gate", gate_w, 0);
    check(level_w == 4'd0, "R9 reset level", level_w, 0);
    rst_n = 1'b1;
    e = 0;

    // R1 / R3: capture only at valley/peak
    cap_check(32767, 256, 1'b1, "R1 setup");
    tick();
    ref_s = -16'sd32768;
    while (!is_peak(e)) begin
      tick();
      check($signed(level_w) == 4, "R3 level held between captures", $signed(level_w), 4);
      check(gate_w == exp_gate(4, half_m, l2_s), "R3 gate held", gate_w, exp_gate(4, half_m, l2_s));
    end
    tick();
    check($signed(level_w) == -4, "R1 level moves at peak edge", $signed(level_w), -4);

    // sweep R2 R4 R5 R6 R7
    for (int mi = 0; mi < 5; mi++) begin
      for (int i = 0; i < 78; i++) begin
        int r;
        if (i < 64) r = -32768 + i * 1024 + ((i * 331) % 1024);
        else r = ((i - 64) / 2 + 1) * 8192 - 32768 + ((i - 64) % 2);
        cap_check(r, mlist[mi], 1'b1, "sweep");
        cap_check(r, mlist[mi], 1'b0, "sweep");
      end
    end

    // R4 explicit
    cap_check(32767, 64, 1'b1, "R4 quarter index");
    check($signed(level_w) == 1, "R4 quarter index reaches +1", $signed(level_w), 1);
    cap_check(32767, 300, 1'b1, "R4 clamp");
    check($signed(level_w) == 4, "R4 index above 256 clamps", $signed(level_w), 4);

    // R6 programmable level +2
    l2_s = 9'b110000011;
    cap_check(8292, 256, 1'b1, "R6 lvl2");
    check(gate_w == 9'b110000011, "R6 level +2 vector", gate_w, 9'b110000011);
    l2_s = 9'b000111000;
    tick();
    check(gate_w == 9'b110000011, "R6 vector held until next capture", gate_w, 9'b110000011);
    l2_s = exp_gate(1, 1'b1, 9'd0);

    // R7 zero-level sets
    cap_check(100, 256, 1'b0, "R7 pos zero");
    check(gate_w == exp_gate(0, 1'b1, l2_s), "R7 zero set positive", gate_w, exp_gate(0, 1'b1, l2_s));
    cap_check(-100, 256, 1'b1, "R7 neg zero");
    check(gate_w == exp_gate(0, 1'b0, l2_s), "R7 zero set negative", gate_w, exp_gate(0, 1'b0, l2_s));
    cap_check(0, 256, 1'b1, "R7 zero ref");
    check(gate_w == exp_gate(0, 1'b0, l2_s), "R7 zero ref holds half", gate_w, exp_gate(0, 1'b0, l2_s));

    // R8 dead time
    dead_s = 8'd0;
    cap_check(32767, 256, 1'b1, "R8 setup");
    oldg = exp_gate(4, 1'b1, l2_s);
    newg = exp_gate(-4, 1'b0, l2_s);
    wait_strobe(1'b0);
    ref_s = -16'sd32768;
    dead_s = 8'd5;
    tick();
    for (int j = 0; j < 5; j++) begin
      check(gate_w == (oldg & newg), $sformatf("R8 new gates held low, cycle %0d", j),
            gate_w, oldg & newg);
      tick();
    end
    check(gate_w == newg, "R8 new gates up after dead time", gate_w, newg);
    check($signed(level_w) == -4, "R8 level during dead time", $signed(level_w), -4);

    summary();
    $finish;
  end
endmodule